// File: doc/BRIEF.md
# PCIe Function Power-State Sequencer

This block keeps the power-management state of one PCIe endpoint function and brings that function back up after a fundamental reset. It watches two kinds of configuration write. The first is a write to the two-bit power-state field. The second is a write to the command register, where only the memory-access-enable bit matters. It also samples the active-low external reset on the core clock.

From those inputs the block reports the current D-state and raises a request for the link to go to L1 while the function sits in D3. It also runs a timed release after the external reset goes away. That release raises an internal power-good and, on its rising edge, requests a reload of the configuration NVM and clears wake-enable. Wake-enable is restored from the loaded APM-enable bit once the NVM reports completion. Separate enables open link training, configuration access and configuration response at their own parameterised delays.

A configuration request that arrives before access is allowed is flagged as early. All delays are counted in core clock cycles from the first clock edge at which the external reset is sampled high.

Top module: `pm_state_seq`

## Requirements
- R1: The D-state reads back on `dstate_o` as 00 = D0 uninitialised, 01 = D0 active, 10 = reset state, 11 = D3. A power-state write of 2'b11 in either D0 state moves to D3 at the next edge and raises `link_l1_req_o`.
- R2: In D3 the function stays in D3 for any number of cycles. Only a power-state write of 2'b00 or the external reset takes it out.
- R3: When `ext_rst_ni` is sampled low in any state, the next cycle shows the reset state (10) with `link_l1_req_o`, `pwr_good_o`, `link_train_en_o`, `cfg_access_en_o` and `cfg_resp_en_o` all low.
- R4: `pwr_good_o` is low until `ext_rst_ni` has been sampled high on T_CLKPR consecutive edges, and is high from that edge on.
- R5: The rising edge of `pwr_good_o` produces a one-cycle `nvm_reload_o` pulse in the same cycle. `wake_en_o` is low from the following cycle on.
- R6: `nvm_done_i` during a reload moves the reset state to D0 uninitialised and loads `wake_en_o` from `nvm_apm_en_i`. If no reload is pending, `nvm_done_i` has no effect.
- R7: `link_train_en_o`, `cfg_access_en_o` and `cfg_resp_en_o` rise after T_PGTRN, T_PGCFG and T_PGRES high-sampled edges respectively.
- R8: A command write with `cmd_mem_en_i` = 1 moves D0 uninitialised to D0 active. A command write with the bit at 0, or any command write in D3, leaves the state unchanged.
- R9: A power-state write of 2'b00 in D3 moves to D0 uninitialised and drops `link_l1_req_o`. In D0 active the same write changes nothing.
- R10: Power-state writes of 2'b01 and 2'b10 leave the state and `link_l1_req_o` unchanged.
- R11: `cfg_early_o` is high in any cycle where `cfg_req_i` is high while `cfg_access_en_o` is low, and low otherwise.
- R12: If `ext_rst_ni` is reasserted partway through the release, every delay restarts from zero at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Core reset, asynchronous active-low |
| ext_rst_ni | input | 1 | External fundamental reset, active-low, sampled on clk_i |
| ps_wr_i | input | 1 | Write strobe for the power-state field |
| ps_data_i | input | 2 | Value written to the power-state field |
| cmd_wr_i | input | 1 | Write strobe for the command register |
| cmd_mem_en_i | input | 1 | Memory-access-enable bit of the command write |
| nvm_done_i | input | 1 | NVM read complete |
| nvm_apm_en_i | input | 1 | APM-enable bit from the loaded configuration |
| cfg_req_i | input | 1 | A configuration request is arriving |
| dstate_o | output | 2 | Current D-state |
| link_l1_req_o | output | 1 | Request for the link to enter L1 |
| pwr_good_o | output | 1 | Internal power-good |
| nvm_reload_o | output | 1 | One-cycle request to re-read the NVM |
| wake_en_o | output | 1 | Wake-up enable |
| link_train_en_o | output | 1 | Link training may start |
| cfg_access_en_o | output | 1 | Configuration access allowed |
| cfg_resp_en_o | output | 1 | Configuration response allowed |
| cfg_early_o | output | 1 | Request arrived before access was allowed |

## Verification
The bench counts every release edge. It checks that power-good and each enable change on exactly their own edge and not one cycle early or late. It also checks that the reload pulse lasts one cycle. A counter that does not clear on a mid-sequence reassertion would let power-good reappear too soon; the restart test catches this. A timeout or stray transition out of D3 would fail the long hold. Decoding the reserved power-state codes as D3 or D0 would move the state during the vector walk. Accepting an NVM completion with no reload pending would leave the reset state early.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;
  typedef enum logic [1:0] {
    DS_D0U = 2'b00,
    DS_D0A = 2'b01,
    DS_RST = 2'b10,
    DS_D3  = 2'b11
  } dstate_e;

  localparam logic [1:0] PS_CODE_D0 = 2'b00;
  localparam logic [1:0] PS_CODE_D3 = 2'b11;

  localparam int unsigned NUM_GATES = 4;
  localparam int unsigned G_PWRGD   = 0;
  localparam int unsigned G_TRAIN   = 1;
  localparam int unsigned G_ACCESS  = 2;
  localparam int unsigned G_RESP    = 3;
endpackage

// File: rtl/pmseq_release_timer.sv
module pmseq_release_timer
  import pmseq_pkg::*;
#(
  parameter int unsigned T_CLKPR = 4,
  parameter int unsigned T_PGTRN = 8,
  parameter int unsigned T_PGCFG = 12,
  parameter int unsigned T_PGRES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_rst_ni,
  output logic [NUM_GATES-1:0] gate_o
);
  localparam int unsigned TMAX_A = (T_CLKPR > T_PGTRN) ? T_CLKPR : T_PGTRN;
  localparam int unsigned TMAX_B = (T_PGCFG > T_PGRES) ? T_PGCFG : T_PGRES;
  localparam int unsigned TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int unsigned CW     = $clog2(TMAX + 1);
  localparam int unsigned THR [NUM_GATES] = '{T_CLKPR, T_PGTRN, T_PGCFG, T_PGRES};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!ext_rst_ni) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CW'(TMAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign gate_o[g] = (cnt_q >= CW'(THR[g]));
  end

  // R3
  gates_clear_on_ext_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> (gate_o == '0));
  // R4
  pwrgd_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_ni && gate_o[G_PWRGD]) |=> gate_o[G_PWRGD]);
  // R12
  pwrgd_rise_needs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[G_PWRGD]) |-> $past(ext_rst_ni));
endmodule

// File: rtl/pmseq_nvm_wake.sv
module pmseq_nvm_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  input  logic pwr_good_i,
  input  logic nvm_done_i,
  input  logic nvm_apm_en_i,
  output logic reload_o,
  output logic load_done_o,
  output logic wake_en_o
);
  logic pg_q;
  logic loading_q, loading_d;
  logic wake_q, wake_d;
  logic pg_rise;

  assign pg_rise     = pwr_good_i & ~pg_q;
  assign reload_o    = pg_rise;
  assign load_done_o = loading_q & nvm_done_i & ext_rst_ni;

  always_comb begin
    loading_d = loading_q;
    wake_d    = wake_q;
    if (!ext_rst_ni) begin
      loading_d = 1'b0;
    end else if (pg_rise) begin
      loading_d = 1'b1;
      wake_d    = 1'b0;
    end else if (load_done_o) begin
      loading_d = 1'b0;
      wake_d    = nvm_apm_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q      <= 1'b0;
      loading_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      pg_q      <= pwr_good_i;
      loading_q <= loading_d;
      wake_q    <= wake_d;
    end
  end

  assign wake_en_o = wake_q;

  // R5
  wake_cleared_after_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> !wake_en_o);
  // R5
  reload_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> !reload_o);
  // R6
  wake_from_nvm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> (wake_en_o == $past(nvm_apm_en_i)));
endmodule

// File: rtl/pmseq_dstate_fsm.sv
module pmseq_dstate_fsm
  import pmseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       load_done_i,
  input  logic       ps_wr_i,
  input  logic [1:0] ps_data_i,
  input  logic       cmd_wr_i,
  input  logic       cmd_mem_en_i,
  output dstate_e    state_o,
  output logic       l1_req_o
);
  dstate_e state_q, state_d;
  logic    l1_q, l1_d;
  logic    go_d3, go_d0, go_active;

  assign go_d3     = ps_wr_i && (ps_data_i == PS_CODE_D3);
  assign go_d0     = ps_wr_i && (ps_data_i == PS_CODE_D0);
  assign go_active = cmd_wr_i && cmd_mem_en_i;

  always_comb begin
    state_d = state_q;
    l1_d    = l1_q;
    if (!ext_rst_ni) begin
      state_d = DS_RST;
      l1_d    = 1'b0;
    end else begin
      unique case (state_q)
        DS_RST: if (load_done_i) state_d = DS_D0U;
        DS_D0U: begin
          if (go_d3) begin
            state_d = DS_D3;
            l1_d    = 1'b1;
          end else if (go_active) begin
            state_d = DS_D0A;
          end
        end
        DS_D0A: begin
          if (go_d3) begin
            state_d = DS_D3;
            l1_d    = 1'b1;
          end
        end
        DS_D3: begin
          if (go_d0) begin
            state_d = DS_D0U;
            l1_d    = 1'b0;
          end
        end
        default: state_d = DS_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DS_RST;
      l1_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      l1_q    <= l1_d;
    end
  end

  assign state_o  = state_q;
  assign l1_req_o = l1_q;

  // R1
  l1_matches_d3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DS_D3) == l1_q);
  // R2
  d3_no_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_ni && state_q == DS_D3 && !go_d0) |=> (state_q == DS_D3));
  // R3
  ext_rst_to_dr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> (state_q == DS_RST && !l1_q));
  // R8
  active_exits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_ni && state_q == DS_D0A) |=> (state_q inside {DS_D0A, DS_D3}));
  // R10
  reserved_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_ni && ps_wr_i && (ps_data_i == 2'b01 || ps_data_i == 2'b10)
     && !cmd_wr_i && state_q != DS_RST) |=> $stable(state_q));
endmodule

// File: rtl/pm_state_seq.sv
module pm_state_seq
  import pmseq_pkg::*;
#(
  parameter int unsigned T_CLKPR = 4,
  parameter int unsigned T_PGTRN = 8,
  parameter int unsigned T_PGCFG = 12,
  parameter int unsigned T_PGRES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       ps_wr_i,
  input  logic [1:0] ps_data_i,
  input  logic       cmd_wr_i,
  input  logic       cmd_mem_en_i,
  input  logic       nvm_done_i,
  input  logic       nvm_apm_en_i,
  input  logic       cfg_req_i,
  output logic [1:0] dstate_o,
  output logic       link_l1_req_o,
  output logic       pwr_good_o,
  output logic       nvm_reload_o,
  output logic       wake_en_o,
  output logic       link_train_en_o,
  output logic       cfg_access_en_o,
  output logic       cfg_resp_en_o,
  output logic       cfg_early_o
);
  logic [NUM_GATES-1:0] gate;
  logic                 load_done;
  dstate_e              state;

  pmseq_release_timer #(
    .T_CLKPR(T_CLKPR), .T_PGTRN(T_PGTRN), .T_PGCFG(T_PGCFG), .T_PGRES(T_PGRES)
  ) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .gate_o(gate)
  );

  pmseq_nvm_wake nvm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni),
    .pwr_good_i(gate[G_PWRGD]), .nvm_done_i(nvm_done_i), .nvm_apm_en_i(nvm_apm_en_i),
    .reload_o(nvm_reload_o), .load_done_o(load_done), .wake_en_o(wake_en_o)
  );

  pmseq_dstate_fsm fsm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .load_done_i(load_done),
    .ps_wr_i(ps_wr_i), .ps_data_i(ps_data_i), .cmd_wr_i(cmd_wr_i),
    .cmd_mem_en_i(cmd_mem_en_i), .state_o(state), .l1_req_o(link_l1_req_o)
  );

  assign dstate_o        = state;
  assign pwr_good_o      = gate[G_PWRGD];
  assign link_train_en_o = gate[G_TRAIN];
  assign cfg_access_en_o = gate[G_ACCESS];
  assign cfg_resp_en_o   = gate[G_RESP];
  assign cfg_early_o     = cfg_req_i & ~gate[G_ACCESS];

  // R6
  leave_dr_only_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == DS_RST && !load_done) |=> (state == DS_RST));
  // R11
  no_early_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_access_en_o |-> !cfg_early_o);
endmodule

// File: tb/pm_state_seq_tb_top.sv
module pm_state_seq_tb_top;
  localparam int T_CLKPR = 4;
  localparam int T_PGTRN = 8;
  localparam int T_PGCFG = 12;
  localparam int T_PGRES = 16;

  logic clk = 1'b0;
  logic rst_ni, ext_rst_ni, ps_wr, cmd_wr, cmd_mem, nvm_done, apm, cfg_req;
  logic [1:0] ps_data;
  logic [1:0] dstate;
  logic l1, pg, reload, wake, train, acc, resp, early;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pm_state_seq #(.T_CLKPR(T_CLKPR), .T_PGTRN(T_PGTRN), .T_PGCFG(T_PGCFG), .T_PGRES(T_PGRES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .ps_wr_i(ps_wr), .ps_data_i(ps_data),
    .cmd_wr_i(cmd_wr), .cmd_mem_en_i(cmd_mem), .nvm_done_i(nvm_done), .nvm_apm_en_i(apm),
    .cfg_req_i(cfg_req), .dstate_o(dstate), .link_l1_req_o(l1), .pwr_good_o(pg),
    .nvm_reload_o(reload), .wake_en_o(wake), .link_train_en_o(train),
    .cfg_access_en_o(acc), .cfg_resp_en_o(resp), .cfg_early_o(early)
  );

  // bits: [7] ps_wr, [6:5] ps_data, [4] cmd_wr, [3] cmd_mem, [2:1] exp state, [0] exp l1
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'b1110_0111,  // R1 D0U -> D3
    8'b1010_0111,  // R10 reserved 01 in D3
    8'b0001_1111,  // R8 command write in D3 ignored
    8'b1000_0000,  // R9 D3 -> D0U
    8'b1100_0000,  // R10 reserved 10 in D0U
    8'b0001_0000,  // R8 command write with bit 0
    8'b0001_1010,  // R8 D0U -> D0A
    8'b1000_0010,  // R9 write 00 in D0A ignored
    8'b1010_0010,  // R10 reserved 01 in D0A
    8'b1110_0111,  // R1 D0A -> D3
    8'b0000_0111,  // R2 idle in D3
    8'b1000_0000   // R9 D3 -> D0U
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    ps_wr = 0; ps_data = 2'b00; cmd_wr = 0; cmd_mem = 0; nvm_done = 0; cfg_req = 0;
  endtask

  // External reset low for one cycle, then check the reset state.
  task automatic pulse_ext_rst();
    @(negedge clk);
    ext_rst_ni = 0;
    step();
    check("R3 dstate", dstate, 2);
    check("R3 l1", l1, 0);
    check("R3 enables", {pg, train, acc, resp}, 0);
  endtask

  // Release and walk every edge of the sequence, then load the NVM.
  task automatic release_seq(input logic prev_wake, input logic apm_val);
    @(negedge clk);
    ext_rst_ni = 1; cfg_req = 1;
    for (int k = 1; k <= T_PGRES; k++) begin
      step();
      check("R4 pwr_good", pg, int'(k >= T_CLKPR));
      check("R7 train", train, int'(k >= T_PGTRN));
      check("R7 access", acc, int'(k >= T_PGCFG));
      check("R7 resp", resp, int'(k >= T_PGRES));
      check("R5 reload", reload, int'(k == T_CLKPR));
      check("R5 wake", wake, (k > T_CLKPR) ? 0 : int'(prev_wake));
      check("R11 early", early, int'(k < T_PGCFG));
      check("R12 still DR", dstate, 2);
    end
    @(negedge clk);
    cfg_req = 0; nvm_done = 1; apm = apm_val;
    step();
    check("R6 to D0U", dstate, 0);
    check("R6 wake load", wake, int'(apm_val));
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; ext_rst_ni = 0; ps_wr = 0; ps_data = 0; cmd_wr = 0; cmd_mem = 0;
    nvm_done = 0; apm = 0; cfg_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    step();
    // R3 reset state
    check("R3 reset dstate", dstate, 2);
    check("R3 reset outputs", {l1, pg, reload, wake, train, acc, resp}, 0);
    check("R11 no request", early, 0);

    // R6 completion with no reload pending is ignored
    @(negedge clk);
    nvm_done = 1;
    step();
    check("R6 stray done", dstate, 2);
    idle_inputs();

    release_seq(1'b0, 1'b1);

    // Vector walk: R1 R2 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ps_wr = VEC[v][7]; ps_data = VEC[v][6:5]; cmd_wr = VEC[v][4]; cmd_mem = VEC[v][3];
      step();
      check($sformatf("R1/R8/R9/R10 vec%0d state", v), dstate, int'(VEC[v][2:1]));
      check($sformatf("R1/R9/R10 vec%0d l1", v), l1, int'(VEC[v][0]));
    end
    idle_inputs();

    // R2 long stay in D3
    @(negedge clk);
    ps_wr = 1; ps_data = 2'b11;
    step();
    idle_inputs();
    repeat (500) @(posedge clk);
    #1;
    check("R2 D3 held", dstate, 3);
    check("R2 l1 held", l1, 1);

    // R3 from D3, then release with APM off
    pulse_ext_rst();
    release_seq(1'b1, 1'b0);

    // R12 reassert partway through the release
    pulse_ext_rst();
    @(negedge clk);
    ext_rst_ni = 1;
    repeat (6) @(posedge clk);
    #1;
    check("R12 mid pg", pg, 1);
    check("R12 mid train", train, 0);
    pulse_ext_rst();
    check("R12 pg dropped", pg, 0);
    release_seq(1'b0, 1'b1);

    // R3 from D0 active
    @(negedge clk);
    cmd_wr = 1; cmd_mem = 1;
    step();
    check("R8 to D0A", dstate, 1);
    idle_inputs();
    pulse_ext_rst();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule